// File: doc/BRIEF.md
# Fault-Tolerant Unit-Stride Vector Load Sequencer

This block runs one unit-stride vector load, plain or segmented, one memory access at a time. The caller starts a job with a base address, the active vector length, the starting element, the field count per element, the element size, and an optional per-element enable mask. Elements are visited in ascending order from the starting element. Within an element, fields are visited in ascending order, and each field's address is its packed position in memory times the element size. Each element's fields are held in a small buffer. They are written to the register write port only once every field of that element has come back without a fault.

A fault handles two ways. A fault on element zero ends the job with a trap pulse, and no result of that element is written. A fault on any later element is not an exception. The job ends quietly, the vector length is cut to that element's index, and nothing from that element onward is requested or written. Every finish reports a new vector length and a new starting element with a one-cycle done pulse.

Top module: `fault_first_loader`

## Requirements
- R1: After reset the block is idle: `busy_o`, `req_valid_o`, `wr_en_o`, `done_o` and `trap_o` are 0, and `new_vl_o` and `new_vstart_o` are 0.
- R2: Element visiting starts at `vstart_i`. If `vstart_i >= vl_i`, the job issues no request and no write, and ends with `new_vl_o = vl_i` and `new_vstart_o = 0`.
- R3: The request for element i, field f has address `base + (i*(nf_m1+1) + f) * 2^esz`, where `esz_i` codes 0,1,2,3 mean 1,2,4,8 bytes and `req_size_o` equals the job's `esz_i`. Requests go in ascending f inside ascending i.
- R4: At most one request is outstanding. No new request is made until `resp_valid_i` has answered the previous one.
- R5: When `mask_en_i` is 1, an element i with `mask_i[i] == 0` gets no request and no write. When `mask_en_i` is 0, all elements are active.
- R6: A write for element i, field f has `wr_idx_o = i` and `wr_reg_o = (reg_base + f*emul) mod 32`. `wr_data_o` is the response data zero-extended from the low `2^esz` bytes. `nf_m1_i` codes the field count minus one (0..7).
- R7: An element's writes appear only after all its fields have returned without a fault, in ascending field order on consecutive cycles. After a fault, no further write appears.
- R8: A fault on element 0 gives `done_o` and `trap_o` together for one cycle, with `new_vl_o = vl_i` and `new_vstart_o = 0`.
- R9: A fault on element i > 0 gives `done_o` without `trap_o`, with `new_vl_o = i` and `new_vstart_o = 0`, and no later request.
- R10: A job without a fault ends with a one-cycle `done_o`, no trap, `new_vl_o = vl_i` and `new_vstart_o = 0`.
- R11: `start_i` while `busy_o` is 1 is ignored. The running job's requests and writes are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a job (taken only when idle) |
| base_addr_i | input | ADDR_W | Base address |
| vl_i | input | VL_W | Active vector length |
| vstart_i | input | VL_W | First element to visit |
| nf_m1_i | input | FN_W | Fields per element minus one |
| esz_i | input | 2 | Element size code (bytes = 2^code) |
| reg_base_i | input | REG_W | First destination register |
| emul_i | input | 4 | Registers per field group (1..8) |
| mask_en_i | input | 1 | Enable the element mask |
| mask_i | input | MAX_VL | Per-element enable bits |
| busy_o | output | 1 | Job in progress |
| req_valid_o | output | 1 | Memory request pulse |
| req_addr_o | output | ADDR_W | Request address |
| req_size_o | output | 2 | Request size code |
| resp_valid_i | input | 1 | Response strobe |
| resp_fault_i | input | 1 | Response is a fault |
| resp_data_i | input | DATA_W | Response data |
| wr_en_o | output | 1 | Register write strobe |
| wr_reg_o | output | REG_W | Destination register |
| wr_idx_o | output | VL_W | Element index within the register group |
| wr_data_o | output | DATA_W | Zero-extended element data |
| done_o | output | 1 | Job finished (one cycle) |
| trap_o | output | 1 | Job finished by an element-0 fault |
| new_vl_o | output | VL_W | Resulting vector length |
| new_vstart_o | output | VL_W | Resulting starting element |

## Verification
On every cycle the assertions check four things: one outstanding request, no write after a fault response, the reported length and start value on each finish, and that a start while busy leaves the latched job unchanged. Only the bench's scenarios can show the rest. These are the exact address order, mask skipping, register numbering and data trimming, and where truncation lands when the first fault falls on a masked-past, later or non-zero field. The bench covers these with directed and seeded random jobs and compares every request and write against its own model.

// File: rtl/ffl_pkg.sv
package ffl_pkg;
  localparam int NF_MAX = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DRAIN = 2'd3
  } ffl_state_e;
endpackage

// File: rtl/ffl_index_math.sv
module ffl_index_math #(
  parameter int ADDR_W = 32,
  parameter int VL_W   = 7,
  parameter int FN_W   = 3,
  parameter int REG_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [VL_W-1:0]   idx_i,
  input  logic [FN_W-1:0]   nf_m1_i,
  input  logic [FN_W-1:0]   req_field_i,
  input  logic [1:0]        esz_i,
  input  logic [REG_W-1:0]  reg_base_i,
  input  logic [3:0]        emul_i,
  input  logic [FN_W-1:0]   wr_field_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  dest_o
);
  // packed slot of (element, field), scaled by element bytes
  function automatic logic [ADDR_W-1:0] slot_addr(
    input logic [ADDR_W-1:0] b, input logic [VL_W-1:0] i,
    input logic [FN_W-1:0] nfm1, input logic [FN_W-1:0] f, input logic [1:0] e);
    logic [ADDR_W-1:0] slot;
    slot = ADDR_W'(i) * (ADDR_W'(nfm1) + ADDR_W'(1)) + ADDR_W'(f);
    return b + (slot << e);
  endfunction

  // destination register of a field group, wrapping the register space
  function automatic logic [REG_W-1:0] group_reg(
    input logic [REG_W-1:0] rb, input logic [FN_W-1:0] f, input logic [3:0] em);
    return rb + REG_W'(REG_W'(f) * REG_W'(em));
  endfunction

  assign addr_o = slot_addr(base_i, idx_i, nf_m1_i, req_field_i, esz_i);
  assign dest_o = group_reg(reg_base_i, wr_field_i, emul_i);
endmodule

// File: rtl/ffl_seg_buffer.sv
module ffl_seg_buffer #(
  parameter int DATA_W = 64,
  parameter int NF_MAX = 8,
  localparam int FN_W  = $clog2(NF_MAX)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [FN_W-1:0]   wfield_i,
  input  logic [1:0]        esz_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [FN_W-1:0]   rfield_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slots_q [NF_MAX];

  // keep only the low 2^esz bytes
  function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] d, input logic [1:0] e);
    logic [DATA_W-1:0] keep;
    keep = (e == 2'd3) ? '1 : ((DATA_W'(1) << (6'd8 << e)) - DATA_W'(1));
    return d & keep;
  endfunction

  always_ff @(posedge clk) begin
    if (we_i) slots_q[wfield_i] <= trim(wdata_i, esz_i);
  end

  assign rdata_o = slots_q[rfield_i];
endmodule

// File: rtl/ffl_seq_fsm.sv
module ffl_seq_fsm
  import ffl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MAX_VL = 64,
  parameter int REG_W  = 5,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int FN_W  = $clog2(NF_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   vstart_i,
  input  logic [FN_W-1:0]   nf_m1_i,
  input  logic [1:0]        esz_i,
  input  logic [REG_W-1:0]  reg_base_i,
  input  logic [3:0]        emul_i,
  input  logic              mask_en_i,
  input  logic [MAX_VL-1:0] mask_i,
  input  logic              resp_valid_i,
  input  logic              resp_fault_i,
  output logic              busy_o,
  output logic              issue_o,
  output logic              accept_ok_o,
  output logic              drain_o,
  output logic [VL_W-1:0]   idx_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [FN_W-1:0]   dptr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [FN_W-1:0]   nf_m1_o,
  output logic [1:0]        esz_o,
  output logic [REG_W-1:0]  reg_base_o,
  output logic [3:0]        emul_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [VL_W-1:0]   new_vl_o,
  output logic [VL_W-1:0]   new_vstart_o
);
  ffl_state_e        state_q;
  logic [VL_W-1:0]   idx_q, vl_q, nvl_q, nvs_q;
  logic [FN_W-1:0]   fn_q, dptr_q, nf_q;
  logic [1:0]        esz_q;
  logic [ADDR_W-1:0] base_q;
  logic [REG_W-1:0]  rbase_q;
  logic [3:0]        emul_q;
  logic              men_q, done_q, trap_q;
  logic [MAX_VL-1:0] mask_q;

  // named internal events
  logic at_end, elem_active, issue_ev, accept_ev, fault_ev, trap_ev, trunc_ev;
  logic finish_ev, drain_ev, last_field, last_drain;

  assign at_end      = (idx_q >= vl_q);
  assign elem_active = !men_q || mask_q[idx_q[IDX_W-1:0]];
  assign issue_ev    = (state_q == ST_SCAN) && !at_end && elem_active;
  assign accept_ev   = (state_q == ST_WAIT) && resp_valid_i;
  assign fault_ev    = accept_ev && resp_fault_i;
  assign trap_ev     = fault_ev && (idx_q == '0);
  assign trunc_ev    = fault_ev && (idx_q != '0);
  assign finish_ev   = (state_q == ST_SCAN) && at_end;
  assign drain_ev    = (state_q == ST_DRAIN);
  assign last_field  = (fn_q == nf_q);
  assign last_drain  = (dptr_q == nf_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
      fn_q    <= '0;
      dptr_q  <= '0;
      nf_q    <= '0;
      esz_q   <= '0;
      base_q  <= '0;
      rbase_q <= '0;
      emul_q  <= '0;
      men_q   <= 1'b0;
      mask_q  <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      nvl_q   <= '0;
      nvs_q   <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q  <= base_addr_i;
            vl_q    <= vl_i;
            idx_q   <= vstart_i;
            nf_q    <= nf_m1_i;
            esz_q   <= esz_i;
            rbase_q <= reg_base_i;
            emul_q  <= emul_i;
            men_q   <= mask_en_i;
            mask_q  <= mask_i;
            fn_q    <= '0;
            dptr_q  <= '0;
            state_q <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (at_end) begin
            done_q  <= 1'b1;
            nvl_q   <= vl_q;
            nvs_q   <= '0;
            state_q <= ST_IDLE;
          end else if (!elem_active) begin
            idx_q <= idx_q + VL_W'(1);
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (trap_ev) begin
            done_q  <= 1'b1;
            trap_q  <= 1'b1;
            nvl_q   <= vl_q;
            nvs_q   <= idx_q;
            state_q <= ST_IDLE;
          end else if (trunc_ev) begin
            done_q  <= 1'b1;
            nvl_q   <= idx_q;
            nvs_q   <= '0;
            state_q <= ST_IDLE;
          end else if (accept_ev) begin
            if (last_field) begin
              dptr_q  <= '0;
              state_q <= ST_DRAIN;
            end else begin
              fn_q    <= fn_q + FN_W'(1);
              state_q <= ST_SCAN;
            end
          end
        end
        ST_DRAIN: begin
          if (last_drain) begin
            idx_q   <= idx_q + VL_W'(1);
            fn_q    <= '0;
            state_q <= ST_SCAN;
          end else begin
            dptr_q <= dptr_q + FN_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign issue_o      = issue_ev;
  assign accept_ok_o  = accept_ev && !resp_fault_i;
  assign drain_o      = drain_ev;
  assign idx_o        = idx_q;
  assign fn_o         = fn_q;
  assign dptr_o       = dptr_q;
  assign base_o       = base_q;
  assign nf_m1_o      = nf_q;
  assign esz_o        = esz_q;
  assign reg_base_o   = rbase_q;
  assign emul_o       = emul_q;
  assign done_o       = done_q;
  assign trap_o       = trap_q;
  assign new_vl_o     = nvl_q;
  assign new_vstart_o = nvs_q;

  // R4: a request is always followed by a waiting cycle
  assert_single_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_ev |=> !issue_ev);
  // R4: nothing new goes out while a response is still owed
  assert_wait_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !resp_valid_i) |=> !issue_ev);
  // R7: a fault response is never followed by a write
  assert_no_write_after_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_ev |=> !drain_ev);
  // R8: a trap keeps the length and reports element zero
  assert_trap_report_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (done_q && nvl_q == vl_q && nvs_q == '0));
  // R9, R10: a quiet finish never grows the length and clears the start
  assert_quiet_finish_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !trap_q) |-> (nvl_q <= vl_q && nvs_q == '0));
  // R11: a start while busy leaves the latched job alone
  assert_busy_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(vl_q) && $stable(base_q) && $stable(nf_q)));
endmodule

// File: rtl/fault_first_loader.sv
module fault_first_loader
  import ffl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int MAX_VL = 64,
  parameter int REG_W  = 5,
  localparam int VL_W  = $clog2(MAX_VL + 1),
  localparam int FN_W  = $clog2(NF_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   vstart_i,
  input  logic [FN_W-1:0]   nf_m1_i,
  input  logic [1:0]        esz_i,
  input  logic [REG_W-1:0]  reg_base_i,
  input  logic [3:0]        emul_i,
  input  logic              mask_en_i,
  input  logic [MAX_VL-1:0] mask_i,
  output logic              busy_o,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [1:0]        req_size_o,
  input  logic              resp_valid_i,
  input  logic              resp_fault_i,
  input  logic [DATA_W-1:0] resp_data_i,
  output logic              wr_en_o,
  output logic [REG_W-1:0]  wr_reg_o,
  output logic [VL_W-1:0]   wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic              trap_o,
  output logic [VL_W-1:0]   new_vl_o,
  output logic [VL_W-1:0]   new_vstart_o
);
  logic              issue_w, accept_ok_w, drain_w;
  logic [VL_W-1:0]   idx_w;
  logic [FN_W-1:0]   fn_w, dptr_w, nf_w;
  logic [ADDR_W-1:0] base_w;
  logic [1:0]        esz_w;
  logic [REG_W-1:0]  rbase_w;
  logic [3:0]        emul_w;

  ffl_seq_fsm #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .REG_W(REG_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .base_addr_i(base_addr_i), .vl_i(vl_i), .vstart_i(vstart_i),
    .nf_m1_i(nf_m1_i), .esz_i(esz_i), .reg_base_i(reg_base_i), .emul_i(emul_i),
    .mask_en_i(mask_en_i), .mask_i(mask_i),
    .resp_valid_i(resp_valid_i), .resp_fault_i(resp_fault_i),
    .busy_o(busy_o), .issue_o(issue_w), .accept_ok_o(accept_ok_w), .drain_o(drain_w),
    .idx_o(idx_w), .fn_o(fn_w), .dptr_o(dptr_w), .base_o(base_w), .nf_m1_o(nf_w),
    .esz_o(esz_w), .reg_base_o(rbase_w), .emul_o(emul_w),
    .done_o(done_o), .trap_o(trap_o), .new_vl_o(new_vl_o), .new_vstart_o(new_vstart_o)
  );

  ffl_index_math #(.ADDR_W(ADDR_W), .VL_W(VL_W), .FN_W(FN_W), .REG_W(REG_W)) u_math (
    .base_i(base_w), .idx_i(idx_w), .nf_m1_i(nf_w), .req_field_i(fn_w),
    .esz_i(esz_w), .reg_base_i(rbase_w), .emul_i(emul_w), .wr_field_i(dptr_w),
    .addr_o(req_addr_o), .dest_o(wr_reg_o)
  );

  ffl_seg_buffer #(.DATA_W(DATA_W), .NF_MAX(NF_MAX)) u_buf (
    .clk(clk), .we_i(accept_ok_w), .wfield_i(fn_w), .esz_i(esz_w),
    .wdata_i(resp_data_i), .rfield_i(dptr_w), .rdata_o(wr_data_o)
  );

  assign req_valid_o = issue_w;
  assign req_size_o  = esz_w;
  assign wr_en_o     = drain_w;
  assign wr_idx_o    = idx_w;

  // R7: writes and requests never share a cycle
  assert_write_not_with_request_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> !req_valid_o);
  // R1: the idle block drives no traffic
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!req_valid_o && !wr_en_o));
endmodule

// File: tb/fault_first_loader_test.sv
module fault_first_loader_test;
  localparam int MAX_VL = 64;
  localparam int VL_W   = 7;
  localparam int EXP_N  = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [6:0]  vl_i = '0, vstart_i = '0;
  logic [2:0]  nf_m1_i = '0;
  logic [1:0]  esz_i = '0;
  logic [4:0]  reg_base_i = '0;
  logic [3:0]  emul_i = 4'd1;
  logic        mask_en_i = 1'b0;
  logic [63:0] mask_i = '0;
  logic        busy_o, req_valid_o, resp_valid_i = 1'b0, resp_fault_i = 1'b0;
  logic [31:0] req_addr_o;
  logic [1:0]  req_size_o;
  logic [63:0] resp_data_i = '0;
  logic        wr_en_o, done_o, trap_o;
  logic [4:0]  wr_reg_o;
  logic [6:0]  wr_idx_o, new_vl_o, new_vstart_o;
  logic [63:0] wr_data_o;

  fault_first_loader uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
    .vl_i(vl_i), .vstart_i(vstart_i), .nf_m1_i(nf_m1_i), .esz_i(esz_i),
    .reg_base_i(reg_base_i), .emul_i(emul_i), .mask_en_i(mask_en_i), .mask_i(mask_i),
    .busy_o(busy_o), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .req_size_o(req_size_o), .resp_valid_i(resp_valid_i), .resp_fault_i(resp_fault_i),
    .resp_data_i(resp_data_i), .wr_en_o(wr_en_o), .wr_reg_o(wr_reg_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o), .trap_o(trap_o),
    .new_vl_o(new_vl_o), .new_vstart_o(new_vstart_o)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // case description
  logic [31:0] c_base, f_addr;
  int          c_vl, c_vs, c_nf1, c_esz, c_rbase, c_emul;
  bit          c_men, f_en;
  logic [63:0] c_mask;

  // expectations
  logic [31:0] e_req [EXP_N];
  logic [4:0]  e_wreg [EXP_N];
  logic [6:0]  e_widx [EXP_N];
  logic [63:0] e_wdat [EXP_N];
  int          n_req, n_wr, e_vl;
  bit          e_trap;
  int          req_ptr, wr_ptr;

  function automatic logic [63:0] mem_word(input logic [31:0] a);
    return {a ^ 32'hA5A5_0F0F, a * 32'h9E37_79B1};
  endfunction

  function automatic logic [63:0] low_bytes(input logic [63:0] d, input int e);
    case (e)
      0: return {56'd0, d[7:0]};
      1: return {48'd0, d[15:0]};
      2: return {32'd0, d[31:0]};
      default: return d;
    endcase
  endfunction

  function automatic logic [31:0] field_addr(input int i, input int f);
    return c_base + 32'((i * (c_nf1 + 1) + f) * (1 << c_esz));
  endfunction

  function automatic bit faults(input logic [31:0] a);
    return f_en && (a >= f_addr);
  endfunction

  task automatic build_exp();
    bit stop = 0;
    n_req = 0; n_wr = 0; e_trap = 0; e_vl = c_vl;
    for (int i = c_vs; i < c_vl && !stop; i++) begin
      if (c_men && !c_mask[i]) continue;
      for (int f = 0; f <= c_nf1; f++) begin
        e_req[n_req] = field_addr(i, f);
        n_req++;
        if (faults(field_addr(i, f))) begin
          if (i == 0) e_trap = 1; else e_vl = i;
          stop = 1;
          break;
        end
      end
      if (!stop)
        for (int f = 0; f <= c_nf1; f++) begin
          e_wreg[n_wr] = 5'((c_rbase + f * c_emul) % 32);
          e_widx[n_wr] = 7'(i);
          e_wdat[n_wr] = low_bytes(mem_word(field_addr(i, f)), c_esz);
          n_wr++;
        end
    end
  endtask

  // memory model and traffic monitor
  bit          pend = 0;
  int          pcnt = 0;
  logic [31:0] paddr;

  always @(negedge clk) begin
    resp_valid_i = 1'b0;
    resp_fault_i = 1'b0;
    if (pend) begin
      pcnt--;
      if (pcnt == 0) begin
        resp_valid_i = 1'b1;
        resp_fault_i = faults(paddr);
        resp_data_i  = mem_word(paddr);
        pend = 0;
      end
    end
    if (rst_n && req_valid_o) begin
      chk(!pend, "R4 request while one outstanding", 1, 0);
      if (req_ptr < n_req) begin
        chk(req_addr_o == e_req[req_ptr], "R3 request address", req_addr_o, e_req[req_ptr]);
        chk(req_size_o == 2'(c_esz), "R3 request size", req_size_o, c_esz);
      end else
        chk(0, "R9 extra request", req_addr_o, 0);
      req_ptr++;
      pend  = 1;
      pcnt  = 1 + int'($urandom % 3);
      paddr = req_addr_o;
    end
    if (rst_n && wr_en_o) begin
      if (wr_ptr < n_wr) begin
        chk(wr_reg_o == e_wreg[wr_ptr], "R6 write register", wr_reg_o, e_wreg[wr_ptr]);
        chk(wr_idx_o == e_widx[wr_ptr], "R6 write index", wr_idx_o, e_widx[wr_ptr]);
        chk(wr_data_o == e_wdat[wr_ptr], "R6 write data", wr_data_o, e_wdat[wr_ptr]);
      end else
        chk(0, "R7 write after fault or extra write", wr_idx_o, 0);
      wr_ptr++;
    end
  end

  task automatic run_case(input string tag, input bit poke);
    int wd = 0;
    build_exp();
    req_ptr = 0; wr_ptr = 0;
    @(negedge clk);
    base_addr_i = c_base; vl_i = 7'(c_vl); vstart_i = 7'(c_vs);
    nf_m1_i = 3'(c_nf1); esz_i = 2'(c_esz); reg_base_i = 5'(c_rbase);
    emul_i = 4'(c_emul); mask_en_i = c_men; mask_i = c_mask;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      chk(busy_o == 1'b1, "R11 busy during job", busy_o, 1);
      base_addr_i = c_base + 32'h400; vl_i = 7'd1; nf_m1_i = 3'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    chk(done_o == 1'b1, {tag, " done seen"}, done_o, 1);
    chk(trap_o == e_trap, {tag, " trap flag"}, trap_o, e_trap);
    chk(new_vl_o == 7'(e_vl), {tag, " new length"}, new_vl_o, e_vl);
    chk(new_vstart_o == 7'd0, {tag, " new start"}, new_vstart_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done is one cycle", done_o, 0);
    chk(req_ptr == n_req, {tag, " request count"}, req_ptr, n_req);
    chk(wr_ptr == n_wr, {tag, " write count"}, wr_ptr, n_wr);
  endtask

  task automatic set_plain(input int vl, input int nf1, input int esz);
    c_base = 32'h0000_1000; c_vl = vl; c_vs = 0; c_nf1 = nf1; c_esz = esz;
    c_rbase = 8; c_emul = 2; c_men = 0; c_mask = '1; f_en = 0; f_addr = '0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !req_valid_o && !wr_en_o, "R1 idle after reset", busy_o, 0);
    chk(!done_o && !trap_o, "R1 no done or trap after reset", done_o, 0);
    chk(new_vl_o == 0 && new_vstart_o == 0, "R1 reported values zero", new_vl_o, 0);

    set_plain(6, 0, 2);                      run_case("R10 plain load", 0);
    set_plain(5, 2, 1); c_vs = 2;            run_case("R2 start mid-vector", 0);
    set_plain(4, 1, 0); c_vs = 4;            run_case("R2 start at length", 0);
    set_plain(3, 1, 0); c_vs = 6;            run_case("R2 start beyond length", 0);
    set_plain(5, 0, 3); f_en = 1; f_addr = field_addr(0, 0);
                                             run_case("R8 fault on element 0", 0);
    set_plain(5, 2, 2); f_en = 1; f_addr = field_addr(0, 2);
                                             run_case("R8 fault on last field of element 0", 0);
    set_plain(8, 1, 1); f_en = 1; f_addr = field_addr(3, 1);
                                             run_case("R9 fault on element 3 field 1", 0);
    set_plain(8, 0, 2); c_men = 1; c_mask = 64'hFC; f_en = 1; f_addr = field_addr(0, 0);
                                             run_case("R9 first active element 2 faults", 0);
    set_plain(10, 1, 0); c_men = 1; c_mask = 64'h2A5;
                                             run_case("R5 masked elements skipped", 0);
    set_plain(10, 1, 0); c_men = 0; c_mask = 64'h0;
                                             run_case("R5 mask off means all active", 0);
    set_plain(64, 7, 3); c_rbase = 30; c_emul = 3;
                                             run_case("R6 full length eight fields", 0);
    set_plain(5, 1, 2);                      run_case("R11 start while busy", 1);

    for (int n = 0; n < 40; n++) begin
      int fe, ff;
      c_base  = 32'($urandom % 32'h10000) << 3;
      c_vl    = int'($urandom % 21);
      c_vs    = int'($urandom % 4);
      c_nf1   = int'($urandom % 4);
      c_esz   = int'($urandom % 4);
      c_rbase = int'($urandom % 32);
      c_emul  = 1 + int'($urandom % 8);
      c_men   = 1'($urandom % 2);
      c_mask  = {$urandom, $urandom};
      f_en    = ($urandom % 3) == 0;
      fe      = int'($urandom % 32'(c_vl + 1));
      ff      = int'($urandom % 32'(c_nf1 + 1));
      f_addr  = field_addr(fe, ff);
      run_case("R3 R7 R9 random job", 0);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nchk++;
        nerr++;
        $display("FAIL watchdog expired after %0d cycles expected completion", cyc);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
      end
    end
  end
endmodule